// File: doc/BRIEF.md
# Video Input Clamp and Gain Controller

This block closes the digital side of the black-level and amplitude loops of a video input channel. Each clock carries one 8-bit ADC sample together with timing qualifiers: a clamp window placed on the back porch, a sync window placed on the sync tip, and a vertical blanking flag. From the back-porch samples it derives a clamp step command (up, down or hold) that pulls the channel toward its black target, and from the sync tips and white peaks it steers a gain code for the input amplifier.

The gain is kept in an 18-bit accumulator whose upper 9 bits are the actual gain. Sync tips that hit code 0 pull it down by a fraction of a gain step per sample, sync tips that never reach code 4 raise it by a full step once per line, samples at 255 cut it by a full step per sample, and a field without any sample above 248 raises it by a full step. The published gain follows the actual gain only when the two have drifted apart by more than a programmable margin, so the amplifier setting does not flicker. All loop activity is frozen during vertical blanking, and with automatic control off a static gain code is passed straight through.

Top module: `afe_level_ctrl`

## Requirements
- R1: With the luma channel selected (chan_sel = 0), clamp_win high and vblank low, a sample below 60 gives clamp_up = 1, above 60 gives clamp_dn = 1, and exactly 60 gives neither; the command appears in the cycle after the sample.
- R2: With the chroma channel selected (chan_sel = 1) the same comparison is made against code 128.
- R3: clamp_up and clamp_dn are never high together, and both are low in the cycle after any sample taken with clamp_win low or vblank high.
- R4: Each sample equal to code 0 inside the sync window lowers the accumulator by 64 (one eighth of a gain step).
- R5: When the sync window closes, the accumulator rises by 512 (one gain step) if the smallest sample in that window was above 4; a smallest sample from 0 to 4 gives no rise.
- R6: Each sample equal to 255 outside the sync window lowers the accumulator by 512; with wp_disable = 1 such samples have no effect on the gain.
- R7: In the first cycle after vblank falls, the accumulator rises by 512 unless some sample above 248 arrived outside the sync window and outside blanking since the previous such cycle (or since reset).
- R8: While vblank is high the accumulator and the published gain do not change.
- R9: The accumulator saturates at 0 and at 262143 and never wraps.
- R10: The published gain takes the actual gain (accumulator bits 17..9) in the cycle after the absolute difference between them exceeds upd_thr, and holds otherwise.
- R11: With auto_en = 0, gain_out equals static_gain and the accumulator holds its value.
- R12: After reset the gain output is 256 (with auto_en = 1) and both clamp commands are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one ADC sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sample | input | 8 | ADC sample, offset binary |
| clamp_win | input | 1 | Back-porch clamp window |
| sync_win | input | 1 | Sync-tip gain window |
| vblank | input | 1 | Vertical blanking, freezes both loops |
| chan_sel | input | 1 | 0 = luma channel, 1 = chroma channel |
| auto_en | input | 1 | 1 = automatic gain, 0 = static gain |
| static_gain | input | 9 | Gain code used when auto_en = 0 |
| wp_disable | input | 1 | 1 = white-peak limiting off |
| upd_thr | input | 3 | Publish margin for the gain output |
| clamp_up | output | 1 | Clamp step up command |
| clamp_dn | output | 1 | Clamp step down command |
| gain_out | output | 9 | Gain code for the input amplifier |

## Verification
The hardest state to reach from the ports is the top end of the accumulator: from the reset gain it takes about 255 full lines whose sync minimum stays above 4 with no white peak, and only then can one check that a further line step does not wrap and that a fractional sync decrement leaves the published code at 511. The stimulus drives the gain to zero with a long burst of white samples and then runs a long directed train of short lines up to the ceiling. Field recovery is equally narrow, since it needs a blanking edge preceded by a whole active period free of near-white samples, so directed fields are run both after a peak and after a clean period before a seeded random phase mixes all windows.

// File: rtl/vcg_pkg.sv
package vcg_pkg;

    localparam int SMP_W  = 8;
    localparam int GAIN_W = 9;
    localparam int FRAC_W = 9;
    localparam int ACC_W  = GAIN_W + FRAC_W;
    localparam int THR_W  = 3;

    localparam logic [SMP_W-1:0] LUMA_LEVEL    = 8'd60;
    localparam logic [SMP_W-1:0] CHROMA_LEVEL  = 8'd128;
    localparam logic [SMP_W-1:0] SYNC_FLOOR    = 8'd1;
    localparam logic [SMP_W-1:0] SYNC_CEIL     = 8'd4;
    localparam logic [SMP_W-1:0] WHITE_LIMIT   = 8'd254;
    localparam logic [SMP_W-1:0] RECOVER_LIMIT = 8'd248;

    typedef enum logic {
        CH_LUMA   = 1'b0,
        CH_CHROMA = 1'b1
    } chan_e;

    typedef enum logic [1:0] {
        CL_HOLD = 2'b00,
        CL_UP   = 2'b01,
        CL_DOWN = 2'b10
    } clamp_e;

    typedef struct packed {
        logic sync_low;
        logic line_gain;
        logic white_peak;
        logic field_gain;
    } gain_evt_t;

    function automatic logic [SMP_W-1:0] clamp_target(chan_e ch);
        return (ch == CH_CHROMA) ? CHROMA_LEVEL : LUMA_LEVEL;
    endfunction

    function automatic logic [GAIN_W-1:0] gain_dist(logic [GAIN_W-1:0] a,
                                                    logic [GAIN_W-1:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/vcg_clamp.sv
module vcg_clamp
    import vcg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] sample,
    input  logic             clamp_win,
    input  logic             vblank,
    input  chan_e            chan,
    output clamp_e           cmd
);

    clamp_e           cmd_d;
    logic [SMP_W-1:0] level;

    always_comb begin
        level = clamp_target(chan);
        cmd_d = CL_HOLD;
        if (clamp_win && !vblank) begin
            if (sample < level)
                cmd_d = CL_UP;
            else if (sample > level)
                cmd_d = CL_DOWN;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cmd <= CL_HOLD;
        else
            cmd <= cmd_d;
    end

endmodule

// File: rtl/vcg_gain_loop.sv
module vcg_gain_loop
    import vcg_pkg::*;
#(
    parameter int unsigned GAIN_RESET    = 256,
    parameter int unsigned STEP_SYNC_DN  = 64,
    parameter int unsigned STEP_LINE_UP  = 512,
    parameter int unsigned STEP_FIELD_UP = 512,
    parameter int unsigned STEP_PEAK_DN  = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SMP_W-1:0] sample,
    input  logic             sync_win,
    input  logic             vblank,
    input  logic             wp_disable,
    output logic [ACC_W-1:0] acc
);

    localparam int SUM_W = ACC_W + 2;
    localparam logic [ACC_W-1:0] ACC_RESET = ACC_W'(GAIN_RESET) << FRAC_W;
    localparam logic [SUM_W-1:0] ACC_CEIL  = SUM_W'({ACC_W{1'b1}});

    logic             sync_d;
    logic             blank_d;
    logic             peak_seen;
    logic [SMP_W-1:0] win_min;
    gain_evt_t        evt;
    logic             line_end;
    logic             field_start;
    logic             recover_hit;
    logic [SUM_W-1:0] up_amt;
    logic [SUM_W-1:0] dn_amt;
    logic [SUM_W-1:0] raised;
    logic [SUM_W-1:0] lowered;
    logic [ACC_W-1:0] acc_d;

    always_comb begin
        line_end    = sync_d & ~sync_win;
        field_start = blank_d & ~vblank;
        recover_hit = ~vblank & ~sync_win & (sample > RECOVER_LIMIT);

        evt.sync_low   = sync_win & (sample < SYNC_FLOOR);
        evt.line_gain  = line_end & (win_min > SYNC_CEIL);
        evt.white_peak = ~sync_win & ~wp_disable & (sample > WHITE_LIMIT);
        evt.field_gain = field_start & ~peak_seen;

        up_amt = (evt.line_gain  ? SUM_W'(STEP_LINE_UP)  : '0)
               + (evt.field_gain ? SUM_W'(STEP_FIELD_UP) : '0);
        dn_amt = (evt.sync_low   ? SUM_W'(STEP_SYNC_DN)  : '0)
               + (evt.white_peak ? SUM_W'(STEP_PEAK_DN)  : '0);

        raised  = SUM_W'(acc) + up_amt;
        lowered = raised - dn_amt;
        if (raised < dn_amt)
            acc_d = '0;
        else if (lowered > ACC_CEIL)
            acc_d = '1;
        else
            acc_d = ACC_W'(lowered);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc       <= ACC_RESET;
            sync_d    <= 1'b0;
            blank_d   <= 1'b0;
            win_min   <= '1;
            peak_seen <= 1'b0;
        end else begin
            sync_d  <= sync_win;
            blank_d <= vblank;
            if (en && !vblank)
                acc <= acc_d;
            if (sync_win)
                win_min <= (!sync_d || sample < win_min) ? sample : win_min;
            if (field_start)
                peak_seen <= recover_hit;
            else if (recover_hit)
                peak_seen <= 1'b1;
        end
    end

endmodule

// File: rtl/vcg_gain_pub.sv
module vcg_gain_pub
    import vcg_pkg::*;
#(
    parameter int unsigned GAIN_RESET = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [GAIN_W-1:0] gain_act,
    input  logic              vblank,
    input  logic [THR_W-1:0]  thr,
    output logic [GAIN_W-1:0] gain_pub
);

    logic [GAIN_W-1:0] drift;
    logic              refresh;

    always_comb begin
        drift   = gain_dist(gain_act, gain_pub);
        refresh = !vblank && (drift > GAIN_W'(thr));
    end

    always_ff @(posedge clk) begin
        if (rst)
            gain_pub <= GAIN_W'(GAIN_RESET);
        else if (refresh)
            gain_pub <= gain_act;
    end

endmodule

// File: rtl/afe_level_ctrl.sv
module afe_level_ctrl
    import vcg_pkg::*;
#(
    parameter int unsigned GAIN_RESET    = 256,
    parameter int unsigned STEP_SYNC_DN  = 64,
    parameter int unsigned STEP_LINE_UP  = 512,
    parameter int unsigned STEP_FIELD_UP = 512,
    parameter int unsigned STEP_PEAK_DN  = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SMP_W-1:0]  sample,
    input  logic              clamp_win,
    input  logic              sync_win,
    input  logic              vblank,
    input  logic              chan_sel,
    input  logic              auto_en,
    input  logic [GAIN_W-1:0] static_gain,
    input  logic              wp_disable,
    input  logic [THR_W-1:0]  upd_thr,
    output logic              clamp_up,
    output logic              clamp_dn,
    output logic [GAIN_W-1:0] gain_out
);

    clamp_e            clamp_cmd;
    logic [ACC_W-1:0]  acc_q;
    logic [GAIN_W-1:0] gain_pub;

    vcg_clamp u_clamp (
        .clk       (clk),
        .rst       (rst),
        .sample    (sample),
        .clamp_win (clamp_win),
        .vblank    (vblank),
        .chan      (chan_e'(chan_sel)),
        .cmd       (clamp_cmd)
    );

    vcg_gain_loop #(
        .GAIN_RESET    (GAIN_RESET),
        .STEP_SYNC_DN  (STEP_SYNC_DN),
        .STEP_LINE_UP  (STEP_LINE_UP),
        .STEP_FIELD_UP (STEP_FIELD_UP),
        .STEP_PEAK_DN  (STEP_PEAK_DN)
    ) u_loop (
        .clk        (clk),
        .rst        (rst),
        .en         (auto_en),
        .sample     (sample),
        .sync_win   (sync_win),
        .vblank     (vblank),
        .wp_disable (wp_disable),
        .acc        (acc_q)
    );

    vcg_gain_pub #(
        .GAIN_RESET (GAIN_RESET)
    ) u_pub (
        .clk      (clk),
        .rst      (rst),
        .gain_act (acc_q[ACC_W-1 -: GAIN_W]),
        .vblank   (vblank),
        .thr      (upd_thr),
        .gain_pub (gain_pub)
    );

    assign clamp_up = (clamp_cmd == CL_UP);
    assign clamp_dn = (clamp_cmd == CL_DOWN);
    assign gain_out = auto_en ? gain_pub : static_gain;

endmodule

// File: rtl/vcg_checker.sv
module vcg_checker
    import vcg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              clamp_win,
    input logic              vblank,
    input logic              auto_en,
    input logic              clamp_up,
    input logic              clamp_dn,
    input logic [ACC_W-1:0]  acc,
    input logic [GAIN_W-1:0] pub
);

    p_clamp_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(clamp_up && clamp_dn));

    p_clamp_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (clamp_up || clamp_dn) |-> $past(clamp_win && !vblank));

    p_acc_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        vblank |=> $stable(acc));

    p_pub_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        vblank |=> $stable(pub));

    p_acc_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !auto_en |=> $stable(acc));

    p_pub_source_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(pub) |-> pub == $past(acc[ACC_W-1 -: GAIN_W]));

endmodule

bind afe_level_ctrl vcg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .clamp_win (clamp_win),
    .vblank    (vblank),
    .auto_en   (auto_en),
    .clamp_up  (clamp_up),
    .clamp_dn  (clamp_dn),
    .acc       (acc_q),
    .pub       (gain_pub)
);

// File: tb/tb_afe_level_ctrl.sv
module tb_afe_level_ctrl;

    logic       clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst;
    logic [7:0] sample;
    logic       clamp_win, sync_win, vblank, chan_sel, auto_en, wp_disable;
    logic [8:0] static_gain;
    logic [2:0] upd_thr;
    logic       clamp_up, clamp_dn;
    logic [8:0] gain_out;

    afe_level_ctrl dut (
        .clk(clk), .rst(rst), .sample(sample), .clamp_win(clamp_win),
        .sync_win(sync_win), .vblank(vblank), .chan_sel(chan_sel),
        .auto_en(auto_en), .static_gain(static_gain), .wp_disable(wp_disable),
        .upd_thr(upd_thr), .clamp_up(clamp_up), .clamp_dn(clamp_dn),
        .gain_out(gain_out)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    finished = 1'b0;
    string cur_tag = "R12";

    // reference state, built from the requirements
    int m_acc, m_pub, m_min;
    bit m_up, m_dn, m_sync_d, m_vb_d, m_seen;

    always @(posedge clk) begin : ref_model
        int g, d, up, dn, tgt, nxt;
        bit line_end, field_start, hit;
        if (rst) begin
            m_acc = 256 * 512; m_pub = 256; m_min = 255;
            m_up = 0; m_dn = 0; m_sync_d = 0; m_vb_d = 0; m_seen = 0;
        end else begin
            g = m_acc / 512;
            d = (g > m_pub) ? g - m_pub : m_pub - g;
            if (!vblank && d > int'(upd_thr)) m_pub = g;
            tgt  = chan_sel ? 128 : 60;
            m_up = clamp_win && !vblank && (int'(sample) < tgt);
            m_dn = clamp_win && !vblank && (int'(sample) > tgt);
            line_end    = m_sync_d && !sync_win;
            field_start = m_vb_d && !vblank;
            hit = !vblank && !sync_win && sample > 248;
            up = 0; dn = 0;
            if (sync_win && sample == 0) dn += 64;
            if (!sync_win && !wp_disable && sample == 255) dn += 512;
            if (line_end && m_min > 4) up += 512;
            if (field_start && !m_seen) up += 512;
            if (auto_en && !vblank) begin
                nxt = m_acc + up - dn;
                if (nxt < 0) nxt = 0;
                if (nxt > 262143) nxt = 262143;
                m_acc = nxt;
            end
            if (sync_win) m_min = (!m_sync_d || int'(sample) < m_min) ? int'(sample) : m_min;
            if (field_start) m_seen = hit; else if (hit) m_seen = 1;
            m_sync_d = sync_win;
            m_vb_d   = vblank;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        chk(cur_tag, "gain_out", int'(gain_out), auto_en ? m_pub : int'(static_gain));
        chk(cur_tag, "clamp_up", int'(clamp_up), int'(m_up));
        chk(cur_tag, "clamp_dn", int'(clamp_dn), int'(m_dn));
    endtask

    task automatic idle(int n);
        sync_win = 0; clamp_win = 0; sample = 8'd100;
        repeat (n) tick();
    endtask

    task automatic line(int minv);
        sync_win = 1; sample = 8'(minv + 2); tick();
        sample = 8'(minv); tick();
        sync_win = 0; sample = 8'd100; tick();
    endtask

    task automatic peaks(int n);
        sync_win = 0; sample = 8'd255;
        repeat (n) tick();
        sample = 8'd100;
    endtask

    task automatic field();
        vblank = 1; repeat (3) tick();
        vblank = 0; tick();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R12 watchdog: actual 200000 cycles expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int g0;
        rst = 1; sample = 8'd100; clamp_win = 0; sync_win = 0; vblank = 0;
        chan_sel = 0; auto_en = 1; wp_disable = 0; static_gain = 9'd0; upd_thr = 3'd0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R12: reset state
        chk("R12", "gain_out", int'(gain_out), 256);
        chk("R12", "clamp_up", int'(clamp_up), 0);
        chk("R12", "clamp_dn", int'(clamp_dn), 0);
        idle(2);

        // R1: luma target 60
        cur_tag = "R1"; clamp_win = 1; chan_sel = 0;
        sample = 8'd59; tick(); chk("R1", "up at 59", int'(clamp_up), 1);
        sample = 8'd60; tick(); chk("R1", "hold at 60", int'(clamp_up | clamp_dn), 0);
        sample = 8'd61; tick(); chk("R1", "down at 61", int'(clamp_dn), 1);
        sample = 8'd0;  tick(); chk("R1", "up at 0", int'(clamp_up), 1);

        // R2: chroma target 128
        cur_tag = "R2"; chan_sel = 1;
        sample = 8'd127; tick(); chk("R2", "up at 127", int'(clamp_up), 1);
        sample = 8'd128; tick(); chk("R2", "hold at 128", int'(clamp_up | clamp_dn), 0);
        sample = 8'd129; tick(); chk("R2", "down at 129", int'(clamp_dn), 1);
        sample = 8'd60;  tick(); chk("R2", "up at 60", int'(clamp_up), 1);

        // R3: outside the window or in blanking there is no command
        cur_tag = "R3"; chan_sel = 0;
        clamp_win = 0; sample = 8'd0; tick();
        chk("R3", "no window", int'(clamp_up | clamp_dn), 0);
        clamp_win = 1; vblank = 1; sample = 8'd200; tick();
        chk("R3", "blanking", int'(clamp_up | clamp_dn), 0);
        vblank = 0; clamp_win = 0; idle(2);

        // R4: zero sync tips lower the gain by an eighth step each
        cur_tag = "R4"; g0 = gain_out;
        sync_win = 1; sample = 8'd0; repeat (16) tick();
        idle(3);
        chk("R4", "16 zero tips", int'(gain_out), g0 - 2);

        // R5: per-line rise only when the window minimum is above 4
        cur_tag = "R5"; g0 = gain_out;
        line(3); line(4); idle(2);
        chk("R5", "minimum 3..4", int'(gain_out), g0);
        line(5); line(10); line(5); idle(2);
        chk("R5", "minimum above 4", int'(gain_out), g0 + 3);

        // R6: white peaks, then limiting switched off
        cur_tag = "R6"; g0 = gain_out;
        peaks(5); idle(2);
        chk("R6", "five peaks", int'(gain_out), g0 - 5);
        g0 = gain_out; wp_disable = 1;
        peaks(5); idle(2);
        chk("R6", "peaks ignored", int'(gain_out), g0);
        wp_disable = 0;

        // R7: field recovery blocked by a near-white sample, then granted
        cur_tag = "R7"; g0 = gain_out;
        field(); idle(2);
        chk("R7", "field after peak", int'(gain_out), g0);
        sample = 8'd249; tick(); idle(2);
        field(); idle(2);
        chk("R7", "field after 249", int'(gain_out), g0);
        idle(4); field(); idle(2);
        chk("R7", "clean field", int'(gain_out), g0 + 1);

        // R8: blanking freezes everything
        cur_tag = "R8"; g0 = gain_out; vblank = 1;
        sync_win = 1; sample = 8'd0; repeat (4) tick();
        sync_win = 0; sample = 8'd255; repeat (4) tick();
        sync_win = 1; sample = 8'd20; repeat (2) tick();
        sync_win = 0; sample = 8'd100; repeat (3) tick();
        chk("R8", "frozen in blanking", int'(gain_out), g0);
        vblank = 0; tick(); idle(2);
        chk("R7", "clean field after freeze", int'(gain_out), g0 + 1);

        // R10: publish margin
        cur_tag = "R10"; g0 = gain_out; upd_thr = 3'd3;
        peaks(3); idle(2);
        chk("R10", "drift 3 held", int'(gain_out), g0);
        peaks(1); idle(2);
        chk("R10", "drift 4 published", int'(gain_out), g0 - 4);
        upd_thr = 3'd0; idle(2);

        // R11: static gain and frozen accumulator
        cur_tag = "R11"; g0 = gain_out;
        auto_en = 0; static_gain = 9'h1A5; tick();
        chk("R11", "static passthrough", int'(gain_out), 9'h1A5);
        peaks(5); line(10); idle(2);
        chk("R11", "static held", int'(gain_out), 9'h1A5);
        auto_en = 1; static_gain = 9'd0; idle(2);
        chk("R11", "accumulator held", int'(gain_out), g0);

        // R9: saturation at both ends
        cur_tag = "R9";
        peaks(600); idle(2);
        chk("R9", "floor", int'(gain_out), 0);
        line(10); idle(2);
        chk("R9", "no wrap below", int'(gain_out), 1);
        repeat (515) line(10);
        idle(2);
        chk("R9", "ceiling", int'(gain_out), 511);
        line(10); idle(2);
        chk("R9", "no wrap above", int'(gain_out), 511);
        sync_win = 1; sample = 8'd0; tick(); idle(3);
        chk("R9", "fraction below ceiling", int'(gain_out), 511);

        // R10: seeded random mix of all windows
        cur_tag = "R10";
        void'($urandom(32'd4242));
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom % 8;
            case (r)
                0: sample = 8'd0;
                1: sample = 8'd255;
                2: sample = 8'($urandom % 6);
                3: sample = 8'(245 + $urandom % 11);
                default: sample = 8'($urandom % 256);
            endcase
            if ($urandom % 6 == 0)   sync_win  = ~sync_win;
            if ($urandom % 5 == 0)   clamp_win = ~clamp_win;
            if ($urandom % 200 == 0) vblank    = ~vblank;
            if ($urandom % 300 == 0) auto_en   = ~auto_en;
            if ($urandom % 150 == 0) wp_disable = ~wp_disable;
            if ($urandom % 100 == 0) upd_thr   = 3'($urandom % 8);
            if ($urandom % 50 == 0)  chan_sel  = ~chan_sel;
            if ($urandom % 100 == 0) static_gain = 9'($urandom % 512);
            tick();
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule